// File: doc/BRIEF.md
# Paged Monochrome Display Buffer Controller

This block holds the frame memory for a 128 by 64 single-colour panel and updates it from a 32-bit register bus. The memory is arranged as eight pages. Each page is 128 bytes, one byte per column, and each byte covers eight vertically stacked pixels. Software first writes a mode register to choose between command handling and pixel-data streaming. It then selects a page, through an instruction register or through the data register while in command mode. After that it streams bytes into the page through the data register. A column pointer advances by one on each stored byte and wraps inside the page.

A separate pixel port takes an x/y coordinate and returns whether that pixel is lit, one cycle later. The same port returns the lit colour. That colour is a fixed base text colour, scaled per channel by a 3-bit brightness level sampled from an input pin. An optional clear input zeroes the whole frame memory in one cycle.

Top module: `mono_panel_buf`

## Requirements
- R1: Register offset 0x180 holds a 32-bit interrupt-control value. A write stores it, and a read returns it on `rdata` in the cycle after `rd_en`. A read of any other address, including an address whose two low bits are not 00, returns zero. `rdata` is zero in any cycle that follows no read, and it is zero after reset.
- R2: A write to offset 0x1AC of exactly 0x00100011 selects data mode, and a write of exactly 0x00104011 selects command mode. Any other value selects the invalid mode.
- R3: In the invalid mode, a write to the data register at offset 0x1C0 changes neither the frame memory nor the page nor the column.
- R4: A write to the instruction register at offset 0x1BC of a 32-bit value from 0xB0 to 0xB7 selects page (value - 0xB0) and sets the column to 0. Any other value, including 0x1B3, changes nothing.
- R5: In command mode, a data-register write is decoded as an instruction under the same rule as R4, and it never stores a byte.
- R6: In data mode, a data-register write stores `wdata[7:0]` at byte address page*128 + column. The column then advances by one modulo 128, and the page does not change.
- R7: One cycle after `px_x`/`px_y` are presented, `px_on` equals bit (y mod 8) of byte x + (y/8)*128.
- R8: `bright` is registered every cycle, and the registered value is 7 after reset. Each colour output is the base colour channel (red 0xE0, green 0xE0, blue 0xFF) times the registered brightness, divided by 7 and rounded down.
- R9: Reset selects page 0, column 0, the invalid mode and interrupt-control value 0. A cycle with `clr` high zeroes every frame-memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero all frame memory this cycle |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bright | input | 3 | Brightness level |
| px_x | input | 7 | Pixel column |
| px_y | input | 6 | Pixel row |
| px_on | output | 1 | Pixel lit, one cycle after coordinates |
| px_r | output | 8 | Scaled red |
| px_g | output | 8 | Scaled green |
| px_b | output | 8 | Scaled blue |

## Verification
The hardest condition to reach is the column pointer passing from 127 back to 0. Getting there takes 129 consecutive data writes to one page. The bench streams that sequence into the last page and then reads back the first, second and last columns. It also reads the neighbouring page to confirm nothing spilled across the page boundary. The invalid-mode case is tested in a similar way. A byte written while the mode is invalid must not move the column, so the bench switches to data mode afterwards and checks that the next byte still lands at column 0.

// File: rtl/mono_panel_buf.sv
module mono_panel_buf #(
  parameter int COLS = 128,
  parameter int PAGES = 8,
  parameter int AW = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [2:0]            bright,
  input  logic [$clog2(COLS)-1:0]    px_x,
  input  logic [$clog2(PAGES)+2:0]   px_y,
  output logic                  px_on,
  output logic [7:0]            px_r,
  output logic [7:0]            px_g,
  output logic [7:0]            px_b
);
  localparam int COL_W = $clog2(COLS);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int DEPTH = COLS * PAGES;
  localparam logic [AW-1:0] OFF_IRQ  = AW'(12'h180);
  localparam logic [AW-1:0] OFF_MODE = AW'(12'h1AC);
  localparam logic [AW-1:0] OFF_INST = AW'(12'h1BC);
  localparam logic [AW-1:0] OFF_DATA = AW'(12'h1C0);
  localparam logic [31:0] MAGIC_DATA = 32'h0010_0011;
  localparam logic [31:0] MAGIC_CMD  = 32'h0010_4011;
  localparam logic [31:0] PG_FIRST = 32'h0000_00B0;
  localparam logic [31:0] PG_LAST  = PG_FIRST + 32'(PAGES - 1);
  localparam logic [1:0] M_OFF = 2'd0, M_DATA = 2'd1, M_CMD = 2'd2;
  localparam logic [7:0] BASE_R = 8'hE0, BASE_G = 8'hE0, BASE_B = 8'hFF;

  logic [7:0]        vram [DEPTH];
  logic [1:0]        mode;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic [31:0]       irq_q;
  logic [2:0]        bright_q;

  function automatic logic [7:0] scale(input logic [7:0] c, input logic [2:0] b);
    logic [10:0] p;
    p = {3'b0, c} * {8'b0, b};
    return 8'(p / 11'd7);
  endfunction

  wire is_page_op = (wdata >= PG_FIRST) && (wdata <= PG_LAST);
  wire wr_inst    = wr_en && addr == OFF_INST;
  wire wr_data    = wr_en && addr == OFF_DATA;
  wire page_sel   = is_page_op && (wr_inst || (wr_data && mode == M_CMD));
  wire store      = wr_data && mode == M_DATA;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_OFF;
      page     <= '0;
      col      <= '0;
      irq_q    <= '0;
      bright_q <= 3'd7;
      rdata    <= '0;
    end else begin
      bright_q <= bright;
      rdata    <= (rd_en && addr == OFF_IRQ) ? irq_q : 32'd0;
      if (wr_en && addr == OFF_IRQ) irq_q <= wdata;
      if (wr_en && addr == OFF_MODE)
        mode <= (wdata == MAGIC_DATA) ? M_DATA :
                (wdata == MAGIC_CMD)  ? M_CMD  : M_OFF;
      if (page_sel) begin
        page <= wdata[PAGE_W-1:0];
        col  <= '0;
      end else if (store) begin
        col <= col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) vram[i] <= 8'h00;
    end else if (rst_n && store) begin
      vram[{page, col}] <= wdata[7:0];
    end
  end

  always_ff @(posedge clk)
    px_on <= vram[{px_y[PAGE_W+2:3], px_x}][px_y[2:0]];

  assign px_r = scale(BASE_R, bright_q);
  assign px_g = scale(BASE_G, bright_q);
  assign px_b = scale(BASE_B, bright_q);
endmodule

// File: rtl/mono_panel_buf_chk.sv
module mono_panel_buf_chk #(
  parameter int AW = 12,
  parameter int PAGE_W = 3,
  parameter int COL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [1:0]        mode,
  input logic [PAGE_W-1:0] page,
  input logic [COL_W-1:0]  col,
  input logic [2:0]        bright_q,
  input logic [7:0]        px_r,
  input logic [7:0]        px_b
);
  a_r1_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != AW'(12'h180)) |=> rdata == 32'd0);

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  a_r2_magic_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12'h1AC) && wdata == 32'h0010_0011) |=> mode == 2'd1);

  a_r3_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12'h1C0) && mode == 2'd0) |=> ($stable(page) && $stable(col)));

  a_r4_inst_page: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12'h1BC) && wdata >= 32'hB0 && wdata <= 32'hB7)
      |=> (col == '0 && page == PAGE_W'($past(wdata))));

  a_r6_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12'h1C0) && mode == 2'd1)
      |=> (col == COL_W'($past(col) + 1'b1) && $stable(page)));

  a_r8_dark: assert property (@(posedge clk) disable iff (!rst_n)
    bright_q == 3'd0 |-> (px_r == 8'd0 && px_b == 8'd0));
endmodule

bind mono_panel_buf mono_panel_buf_chk #(.AW(AW), .PAGE_W(PAGE_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .mode(mode), .page(page), .col(col),
  .bright_q(bright_q), .px_r(px_r), .px_b(px_b)
);

// File: tb/mono_panel_buf_test.sv
module mono_panel_buf_test;
  logic        clk = 0, rst_n = 0, clr = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0]  bright = 3'd0;
  logic [6:0]  px_x = '0;
  logic [5:0]  px_y = '0;
  logic        px_on;
  logic [7:0]  px_r, px_g, px_b;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [1024];
  int m_page = 0, m_col = 0, m_mode = 0;

  always #2 clk = ~clk;

  mono_panel_buf uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    if (a == 12'h1AC) m_mode = (d == 32'h00100011) ? 1 : (d == 32'h00104011) ? 2 : 0;
    if ((a == 12'h1BC || (a == 12'h1C0 && m_mode == 2)) && d >= 32'hB0 && d <= 32'hB7) begin
      m_page = int'(d - 32'hB0); m_col = 0;
    end else if (a == 12'h1C0 && m_mode == 1) begin
      model[m_page*128 + m_col] = d[7:0]; m_col = (m_col + 1) % 128;
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic chk_byte(input string req, input int pg, input int cl);
    logic [7:0] got;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); px_x = 7'(cl); px_y = 6'(pg*8 + b);
      @(negedge clk); got[b] = px_on;
    end
    chk(req, {24'd0, got}, {24'd0, model[pg*128 + cl]});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 rdata reset", rdata, 0);
    chk("R8 red at reset brightness", {24'd0, px_r}, 32'hE0);
    chk("R8 blue at reset brightness", {24'd0, px_b}, 32'hFF);
    bright = 3'd7;
    @(negedge clk); rst_n = 1; clr = 1;
    @(negedge clk); clr = 0;
    for (int i = 0; i < 1024; i++) model[i] = 8'h00;
    chk_byte("R9 cleared byte", 3, 77);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    rd(12'h180, d); chk("R9 irq reset", d, 0);
    wr(12'h180, 32'hDEADBEEF);
    rd(12'h180, d); chk("R1 irq readback", d, 32'hDEADBEEF);
    rd(12'h184, d); chk("R1 undecoded", d, 0);
    rd(12'h181, d); chk("R1 misaligned", d, 0);
    @(negedge clk); chk("R1 idle zero", rdata, 0);
  endtask

  task automatic t_data;
    wr(12'h1AC, 32'h00100011);
    wr(12'h1BC, 32'hB2);
    wr(12'h1C0, 32'h123456A5);
    wr(12'h1C0, 32'h3C);
    chk_byte("R6 first byte page2", 2, 0);
    chk_byte("R6 second byte page2", 2, 1);
    chk_byte("R7 untouched neighbour", 2, 2);
  endtask

  task automatic t_wrap;
    wr(12'h1BC, 32'hB7);
    for (int i = 0; i < 129; i++) wr(12'h1C0, 32'(i + 1));
    chk_byte("R6 wrap overwrote col0", 7, 0);
    chk_byte("R6 col1 after wrap", 7, 1);
    chk_byte("R6 col127", 7, 127);
    chk_byte("R6 no spill into page6", 6, 0);
  endtask

  task automatic t_invalid;
    wr(12'h1AC, 32'h00100010);
    wr(12'h1BC, 32'hB1);
    wr(12'h1C0, 32'hFF);
    chk_byte("R3 invalid write ignored", 1, 0);
    wr(12'h1AC, 32'h00100011);
    wr(12'h1C0, 32'h81);
    chk_byte("R3 column unmoved", 1, 0);
    chk_byte("R3 next column empty", 1, 1);
  endtask

  task automatic t_cmd;
    wr(12'h1AC, 32'h00104011);
    wr(12'h1C0, 32'hB4);
    wr(12'h1C0, 32'h55);
    wr(12'h1AC, 32'h00100011);
    wr(12'h1C0, 32'h0F);
    chk_byte("R5 cmd page select", 4, 0);
    wr(12'h1BC, 32'h1B3);
    wr(12'h1C0, 32'hF0);
    chk_byte("R4 wide value ignored", 4, 1);
    chk_byte("R4 page3 untouched", 3, 0);
  endtask

  task automatic t_bright;
    bright = 3'd3; @(negedge clk); @(negedge clk);
    chk("R8 red b3", {24'd0, px_r}, 96); chk("R8 blue b3", {24'd0, px_b}, 109);
    bright = 3'd5; @(negedge clk); @(negedge clk);
    chk("R8 green b5", {24'd0, px_g}, 160); chk("R8 blue b5", {24'd0, px_b}, 182);
    bright = 3'd0; @(negedge clk); @(negedge clk);
    chk("R8 red b0", {24'd0, px_r}, 0);
    bright = 3'd7; @(negedge clk); @(negedge clk);
    chk("R8 blue b7", {24'd0, px_b}, 32'hFF);
  endtask

  initial begin
    t_reset(); t_irq(); t_data(); t_wrap(); t_invalid(); t_cmd(); t_bright();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule